// File: doc/BRIEF.md
# Interrupt Source Controller

This block keeps the per-source state of a bank of interrupt inputs and turns activity on those inputs into interrupt offers for a downstream presentation stage. Each source has a target server, a priority, a remembered priority, a type (edge-style message or level-style line) and a small set of status flags. Interrupt numbers seen on every interface are the source index plus a fixed base. A priority of all ones means the source is masked.

The presentation stage talks back with three strobes. A reject hands a previously offered interrupt back to its source. An end-of-interrupt releases a level source. A resend request starts a scan over every source in ascending index order, one source per cycle, in which rejected or still-active sources offer themselves again. A configuration port sets the target and priority of a source, reads them back, disables a source while remembering its priority, and re-enables it. Offers leave through a valid/ready handshake, and the block produces at most one offer per cycle.

Top module: `irqsrc_ctrl`

## Requirements
- R1: After reset, every source reads back server 0 and priority 0xFF, all status flags are clear, no offer is pending and no scan runs.
- R2: A rising edge on a message source line offers interrupt number index+BASE at the source's priority to its server when the priority is not 0xFF. When the priority is 0xFF, it records a masked-pending flag and produces no offer. No offer ever carries priority 0xFF or a number outside BASE..BASE+NUM_SRC-1.
- R3: A level source records its line as an asserted flag. It offers itself only when its priority is not 0xFF, it is asserted and its sent flag is clear, and then it sets the sent flag, so a line held high produces one offer.
- R4: A reject naming a source sets its rejected flag and clears its sent flag, for either source type.
- R5: During a resend scan, a message source with the rejected flag clears that flag and offers itself again only if its priority is not 0xFF. A level source applies the R3 rule.
- R6: An end-of-interrupt clears the sent flag of a level source and has no effect on a message source.
- R7: Configuration command codes on cfg_op are 0 set, 1 get, 2 disable and 3 enable. Every accepted command is answered with cfg_done one cycle later. Set writes server, priority and remembered priority together. After it, a message source with masked-pending and a new priority other than 0xFF clears the flag and offers itself. A level source applies R3. Get returns server and priority on cfg_rd_server and cfg_rd_prio, which are zero for the other commands.
- R8: Disable sets the priority to 0xFF and keeps the previous priority as the remembered one. Enable copies the remembered priority back.
- R9: A command whose number is outside BASE..BASE+NUM_SRC-1 is answered with cfg_err high and changes nothing. So is a set whose server is not below NUM_SERVERS.
- R10: An offer whose offer_ready is low holds its server, number and priority stable until it is taken. cfg_ready is low while an offer is held.
- R11: A resend scan visits sources in ascending index order. Line events that arrive during a scan are served only after the scan ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | NUM_SRC | Interrupt lines, one per source |
| src_is_level | input | NUM_SRC | Source type: 1 level, 0 message |
| resend_req | input | 1 | Strobe: start a resend scan |
| reject_valid | input | 1 | Strobe: an offered interrupt is handed back |
| reject_num | input | NUM_W | Number being rejected |
| eoi_valid | input | 1 | Strobe: end of interrupt |
| eoi_num | input | NUM_W | Number being completed |
| cfg_valid | input | 1 | Configuration command present |
| cfg_ready | output | 1 | Command accepted this cycle when valid |
| cfg_op | input | 2 | Command code (see R7) |
| cfg_num | input | NUM_W | Interrupt number addressed |
| cfg_server | input | SRV_W | New target server (set) |
| cfg_prio | input | PRIO_W | New priority (set) |
| cfg_done | output | 1 | Response strobe, one cycle after acceptance |
| cfg_err | output | 1 | Response: command rejected |
| cfg_rd_server | output | SRV_W | Response: server read back |
| cfg_rd_prio | output | PRIO_W | Response: priority read back |
| offer_valid | output | 1 | Offer present |
| offer_ready | input | 1 | Presentation stage takes the offer |
| offer_server | output | SRV_W | Target server of the offer |
| offer_num | output | NUM_W | Interrupt number of the offer |
| offer_prio | output | PRIO_W | Priority of the offer |
| scan_busy | output | 1 | A resend scan is in progress |

## Verification
The hardest case to reach is a line event that collides with a running resend scan. The ordering rule only shows when a low-index message edge arrives in the same cycle that a scan starts, and a higher-index source is waiting with its rejected flag set. The bench first rejects source 9. It then raises the resend strobe and the source 0 line together, and expects the scan's offer for source 9 to come out before the offer for source 0. Backpressure is reached by holding offer_ready low across a message edge. The bench then confirms that the offer stays frozen and that configuration is refused until the offer is taken.

// File: rtl/irqsrc_pkg.sv
// Package: shared types for the interrupt source controller.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package irqsrc_pkg;

    // Configuration command codes carried on cfg_op
    typedef enum logic [1:0] {
        CFG_SET = 2'd0,
        CFG_GET = 2'd1,
        CFG_OFF = 2'd2,
        CFG_ON  = 2'd3
    } cfg_op_e;

    // Which kind of work the engine does in a given cycle
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_CFG  = 2'd1,
        ACT_SCAN = 2'd2,
        ACT_LINE = 2'd3
    } act_e;

    // Per-source status flags
    typedef struct packed {
        logic mpend;     // message fired while masked
        logic asserted;  // level line last seen high
        logic sent;      // level offer outstanding
        logic rejected;  // offer handed back, waiting for a scan
    } src_stat_t;

endpackage

// File: rtl/irqsrc_pick.sv
// Module: irqsrc_pick
// Finds the lowest-numbered set bit of a request vector.
// Assumes: N >= 1; idx is meaningless when any is low.
module irqsrc_pick #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so the lowest set bit is the last one written
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                any = 1'b1;
                idx = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/irqsrc_entry.sv
// Module: irqsrc_entry
// State of one interrupt source: target, priority, remembered priority,
// status flags and the captured message edge. It applies the reject and
// end-of-interrupt strobes itself and the engine's decisions as commands.
// Assumes: at most one engine action per cycle targets this entry.
module irqsrc_entry
    import irqsrc_pkg::*;
#(
    parameter int SRV_W  = 4,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_level,
    input  logic              line,
    input  logic              rej_hit,
    input  logic              eoi_hit,
    input  logic              upd_cfg,
    input  logic [SRV_W-1:0]  new_server,
    input  logic [PRIO_W-1:0] new_prio,
    input  logic [PRIO_W-1:0] new_saved,
    input  logic              act_offer,
    input  logic              act_take_line,
    input  logic              act_clr_rej,
    input  logic              act_set_mpend,
    input  logic              act_clr_mpend,
    input  logic              act_clr_fire,
    output logic [SRV_W-1:0]  server,
    output logic [PRIO_W-1:0] prio,
    output logic [PRIO_W-1:0] saved,
    output src_stat_t         eff_stat,
    output logic              fire_pend,
    output logic              line_evt
);

    src_stat_t stat_q;
    logic      line_q;

    // Status as seen by the engine, with this cycle's strobes already folded in
    always_comb begin
        eff_stat          = stat_q;
        eff_stat.sent     = stat_q.sent & ~rej_hit & ~(eoi_hit & is_level);
        eff_stat.rejected = stat_q.rejected | rej_hit;
    end

    // A level source needs attention when its line differs from the recorded state
    assign line_evt = is_level & (line != stat_q.asserted);

    // Configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            server <= '0;
            prio   <= '1;
            saved  <= '1;
        end else if (upd_cfg) begin
            server <= new_server;
            prio   <= new_prio;
            saved  <= new_saved;
        end
    end

    // Status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q.asserted <= act_take_line ? line : stat_q.asserted;
            stat_q.sent     <= (act_offer & is_level) ? 1'b1 : eff_stat.sent;
            stat_q.rejected <= act_clr_rej ? 1'b0 : eff_stat.rejected;
            if (act_set_mpend) begin
                stat_q.mpend <= 1'b1;
            end else if (act_clr_mpend) begin
                stat_q.mpend <= 1'b0;
            end
        end
    end

    // Message edge capture; a new edge wins over the clear of an older one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q    <= 1'b0;
            fire_pend <= 1'b0;
        end else begin
            line_q <= line;
            if (line & ~line_q & ~is_level) begin
                fire_pend <= 1'b1;
            end else if (act_clr_fire) begin
                fire_pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irqsrc_ctrl.sv
// Module: irqsrc_ctrl (top)
// Source layer of an interrupt controller. A single engine does at most one
// piece of offer-capable work per cycle, in this priority order: a
// configuration command, one step of a resend scan, then the lowest-index
// pending line event. Rejects and end-of-interrupt strobes update status
// every cycle regardless of the engine.
// Assumes: the offer stage follows valid/ready; strobes last one cycle.
module irqsrc_ctrl
    import irqsrc_pkg::*;
#(
    parameter int NUM_SRC     = 16,
    parameter int NUM_SERVERS = 3,
    parameter int SRV_W       = 4,
    parameter int PRIO_W      = 8,
    parameter int NUM_W       = 12,
    parameter int BASE        = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] line_in,
    input  logic [NUM_SRC-1:0] src_is_level,
    input  logic               resend_req,
    input  logic               reject_valid,
    input  logic [NUM_W-1:0]   reject_num,
    input  logic               eoi_valid,
    input  logic [NUM_W-1:0]   eoi_num,
    input  logic               cfg_valid,
    output logic               cfg_ready,
    input  logic [1:0]         cfg_op,
    input  logic [NUM_W-1:0]   cfg_num,
    input  logic [SRV_W-1:0]   cfg_server,
    input  logic [PRIO_W-1:0]  cfg_prio,
    output logic               cfg_done,
    output logic               cfg_err,
    output logic [SRV_W-1:0]   cfg_rd_server,
    output logic [PRIO_W-1:0]  cfg_rd_prio,
    output logic               offer_valid,
    input  logic               offer_ready,
    output logic [SRV_W-1:0]   offer_server,
    output logic [NUM_W-1:0]   offer_num,
    output logic [PRIO_W-1:0]  offer_prio,
    output logic               scan_busy
);

    localparam int                IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [PRIO_W-1:0] MASKED   = '1;
    localparam logic [NUM_W-1:0]  BASE_N   = NUM_W'(BASE);
    localparam logic [NUM_W-1:0]  CNT_N    = NUM_W'(NUM_SRC);
    localparam logic [SRV_W:0]    SRV_LIM  = (SRV_W + 1)'(NUM_SERVERS);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_SRC - 1);

    // Per-source state gathered from the entries
    logic [SRV_W-1:0]  e_server [NUM_SRC];
    logic [PRIO_W-1:0] e_prio   [NUM_SRC];
    logic [PRIO_W-1:0] e_saved  [NUM_SRC];
    src_stat_t         e_stat   [NUM_SRC];
    logic [NUM_SRC-1:0] e_fire;
    logic [NUM_SRC-1:0] e_lvl_evt;

    // Scan control
    logic [IDX_W-1:0] scan_idx;
    logic             scan_again;

    // Engine signals
    logic             slot_free;
    logic             cfg_take;
    logic [NUM_W-1:0] cfg_off;
    logic             cfg_in_range;
    logic             srv_ok;
    logic             cfg_ok;
    logic             cfg_mutate;
    cfg_op_e          op;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    act_e             act;
    logic [IDX_W-1:0] sel;

    // Selected source view and computed updates
    logic              s_lvl;
    src_stat_t         s_st;
    logic [SRV_W-1:0]  s_srv;
    logic [PRIO_W-1:0] s_prio;
    logic [PRIO_W-1:0] s_saved;
    logic [SRV_W-1:0]  n_srv;
    logic [PRIO_W-1:0] n_prio;
    logic [PRIO_W-1:0] n_saved;
    logic [PRIO_W-1:0] eff_prio;
    logic [SRV_W-1:0]  eff_srv;
    logic              asrt_v;
    logic              lvl_go;
    logic              do_offer;
    logic              d_take_line;
    logic              d_clr_rej;
    logic              d_set_mp;
    logic              d_clr_mp;
    logic              d_clr_fire;

    // Command decode and acceptance
    always_comb begin
        op           = cfg_op_e'(cfg_op);
        slot_free    = !offer_valid || offer_ready;
        cfg_take     = cfg_valid && slot_free;
        cfg_off      = cfg_num - BASE_N;
        cfg_in_range = (cfg_num >= BASE_N) && (cfg_off < CNT_N);
        srv_ok       = ({1'b0, cfg_server} < SRV_LIM);
        cfg_ok       = cfg_take && cfg_in_range && ((op != CFG_SET) || srv_ok);
        cfg_mutate   = cfg_ok && (op != CFG_GET);
    end

    assign cfg_ready = slot_free;

    irqsrc_pick #(
        .N     (NUM_SRC),
        .IDX_W (IDX_W)
    ) u_pick (
        .req (e_fire | e_lvl_evt),
        .any (pick_any),
        .idx (pick_idx)
    );

    // Choose this cycle's work and the source it concerns
    always_comb begin
        act = ACT_NONE;
        sel = cfg_off[IDX_W-1:0];
        if (cfg_ok) begin
            act = ACT_CFG;
        end else if (slot_free && !cfg_take && scan_busy) begin
            act = ACT_SCAN;
            sel = scan_idx;
        end else if (slot_free && !cfg_take && pick_any) begin
            act = ACT_LINE;
            sel = pick_idx;
        end
    end

    // Read the selected source
    always_comb begin
        s_lvl   = src_is_level[sel];
        s_st    = e_stat[sel];
        s_srv   = e_server[sel];
        s_prio  = e_prio[sel];
        s_saved = e_saved[sel];
    end

    // Field values a configuration command would write
    always_comb begin
        n_srv   = s_srv;
        n_prio  = s_prio;
        n_saved = s_saved;
        case (op)
            CFG_SET: begin
                n_srv   = cfg_server;
                n_prio  = cfg_prio;
                n_saved = cfg_prio;
            end
            CFG_OFF: begin
                n_prio  = MASKED;
                n_saved = s_prio;
            end
            CFG_ON: begin
                n_prio  = s_saved;
                n_saved = s_saved;
            end
            default: ;
        endcase
    end

    // Offer decision for the selected source
    always_comb begin
        do_offer    = 1'b0;
        d_take_line = 1'b0;
        d_clr_rej   = 1'b0;
        d_set_mp    = 1'b0;
        d_clr_mp    = 1'b0;
        d_clr_fire  = 1'b0;
        eff_prio    = (act == ACT_CFG && cfg_mutate) ? n_prio : s_prio;
        eff_srv     = (act == ACT_CFG && cfg_mutate) ? n_srv  : s_srv;
        asrt_v      = (act == ACT_LINE && s_lvl) ? line_in[sel] : s_st.asserted;
        lvl_go      = s_lvl && (eff_prio != MASKED) && asrt_v && !s_st.sent;
        case (act)
            ACT_CFG: begin
                if (cfg_mutate) begin
                    if (s_lvl) begin
                        do_offer = lvl_go;
                    end else if (s_st.mpend && (n_prio != MASKED)) begin
                        d_clr_mp = 1'b1;
                        do_offer = 1'b1;
                    end
                end
            end
            ACT_SCAN: begin
                if (s_lvl) begin
                    do_offer = lvl_go;
                end else if (s_st.rejected) begin
                    d_clr_rej = 1'b1;
                    do_offer  = (s_prio != MASKED);
                end
            end
            ACT_LINE: begin
                if (s_lvl) begin
                    d_take_line = 1'b1;
                    do_offer    = lvl_go;
                end else begin
                    d_clr_fire = 1'b1;
                    if (s_prio == MASKED) begin
                        d_set_mp = 1'b1;
                    end else begin
                        do_offer = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    // One entry per source
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic hit;
        logic rej_hit;
        logic eoi_hit;

        assign hit     = (act != ACT_NONE) && (sel == IDX_W'(i));
        assign rej_hit = reject_valid && (reject_num == BASE_N + NUM_W'(i));
        assign eoi_hit = eoi_valid && (eoi_num == BASE_N + NUM_W'(i));

        irqsrc_entry #(
            .SRV_W  (SRV_W),
            .PRIO_W (PRIO_W)
        ) u_entry (
            .clk           (clk),
            .rst_n         (rst_n),
            .is_level      (src_is_level[i]),
            .line          (line_in[i]),
            .rej_hit       (rej_hit),
            .eoi_hit       (eoi_hit),
            .upd_cfg       (hit && cfg_mutate),
            .new_server    (n_srv),
            .new_prio      (n_prio),
            .new_saved     (n_saved),
            .act_offer     (hit && do_offer),
            .act_take_line (hit && d_take_line),
            .act_clr_rej   (hit && d_clr_rej),
            .act_set_mpend (hit && d_set_mp),
            .act_clr_mpend (hit && d_clr_mp),
            .act_clr_fire  (hit && d_clr_fire),
            .server        (e_server[i]),
            .prio          (e_prio[i]),
            .saved         (e_saved[i]),
            .eff_stat      (e_stat[i]),
            .fire_pend     (e_fire[i]),
            .line_evt      (e_lvl_evt[i])
        );
    end

    // Offer register: load a new offer or drop the taken one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offer_valid  <= 1'b0;
            offer_server <= '0;
            offer_num    <= '0;
            offer_prio   <= '0;
        end else if (do_offer) begin
            offer_valid  <= 1'b1;
            offer_server <= eff_srv;
            offer_num    <= BASE_N + NUM_W'(sel);
            offer_prio   <= eff_prio;
        end else if (offer_ready) begin
            offer_valid  <= 1'b0;
        end
    end

    // Configuration response, one cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_done      <= 1'b0;
            cfg_err       <= 1'b0;
            cfg_rd_server <= '0;
            cfg_rd_prio   <= '0;
        end else begin
            cfg_done      <= cfg_take;
            cfg_err       <= cfg_take && !cfg_ok;
            cfg_rd_server <= (cfg_ok && op == CFG_GET) ? s_srv  : '0;
            cfg_rd_prio   <= (cfg_ok && op == CFG_GET) ? s_prio : '0;
        end
    end

    // Resend scan sequencing, with one queued restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_busy  <= 1'b0;
            scan_idx   <= '0;
            scan_again <= 1'b0;
        end else if (act == ACT_SCAN) begin
            if (scan_idx == LAST_IDX) begin
                scan_busy  <= scan_again || resend_req;
                scan_again <= 1'b0;
                scan_idx   <= '0;
            end else begin
                scan_idx <= scan_idx + 1'b1;
                if (resend_req) begin
                    scan_again <= 1'b1;
                end
            end
        end else if (resend_req) begin
            if (scan_busy) begin
                scan_again <= 1'b1;
            end else begin
                scan_busy <= 1'b1;
                scan_idx  <= '0;
            end
        end
    end

endmodule

// File: rtl/irqsrc_ctrl_chk.sv
// Module: irqsrc_ctrl_chk
// Port-level properties of the interrupt source controller, bound to the top.
// Assumes: reset is synchronous and active low.
module irqsrc_ctrl_chk #(
    parameter int NUM_SRC = 16,
    parameter int SRV_W   = 4,
    parameter int PRIO_W  = 8,
    parameter int NUM_W   = 12,
    parameter int BASE    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_valid,
    input logic              cfg_ready,
    input logic [NUM_W-1:0]  cfg_num,
    input logic              cfg_done,
    input logic              cfg_err,
    input logic              offer_valid,
    input logic              offer_ready,
    input logic [SRV_W-1:0]  offer_server,
    input logic [NUM_W-1:0]  offer_num,
    input logic [PRIO_W-1:0] offer_prio
);

    localparam logic [NUM_W-1:0] LO = NUM_W'(BASE);
    localparam logic [NUM_W-1:0] HI = NUM_W'(BASE + NUM_SRC);

    // A held offer keeps its contents
    assert_offer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid && !offer_ready |=> offer_valid && $stable(offer_num)
            && $stable(offer_prio) && $stable(offer_server));

    // No offer is ever made at the masking priority (R3 relies on the same rule)
    assert_no_masked_offer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> offer_prio != '1);

    // Offered numbers stay inside the source range
    assert_offer_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> (offer_num >= LO) && (offer_num < HI));

    // Out-of-range numbers are answered with an error
    assert_bad_num_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_ready && ((cfg_num < LO) || (cfg_num >= HI))
            |=> cfg_done && cfg_err);

    // Every accepted command gets a response next cycle
    assert_cfg_answer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_ready |=> cfg_done);

    // No response without an accepted command
    assert_cfg_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid && cfg_ready) |=> !cfg_done);

endmodule

bind irqsrc_ctrl irqsrc_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .SRV_W   (SRV_W),
    .PRIO_W  (PRIO_W),
    .NUM_W   (NUM_W),
    .BASE    (BASE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_valid    (cfg_valid),
    .cfg_ready    (cfg_ready),
    .cfg_num      (cfg_num),
    .cfg_done     (cfg_done),
    .cfg_err      (cfg_err),
    .offer_valid  (offer_valid),
    .offer_ready  (offer_ready),
    .offer_server (offer_server),
    .offer_num    (offer_num),
    .offer_prio   (offer_prio)
);

// File: tb/irqsrc_ctrl_bench.sv
// Bench for irqsrc_ctrl: a table of configuration commands, then directed cases.
module irqsrc_ctrl_bench;

    localparam int NUM_SRC = 16;
    localparam int SRV_W   = 4;
    localparam int PRIO_W  = 8;
    localparam int NUM_W   = 12;
    localparam int BASE    = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] line_in = '0;
    logic [NUM_SRC-1:0] src_is_level = 16'h00F0;
    logic               resend_req = 1'b0;
    logic               reject_valid = 1'b0;
    logic [NUM_W-1:0]   reject_num = '0;
    logic               eoi_valid = 1'b0;
    logic [NUM_W-1:0]   eoi_num = '0;
    logic               cfg_valid = 1'b0;
    logic               cfg_ready;
    logic [1:0]         cfg_op = '0;
    logic [NUM_W-1:0]   cfg_num = '0;
    logic [SRV_W-1:0]   cfg_server = '0;
    logic [PRIO_W-1:0]  cfg_prio = '0;
    logic               cfg_done;
    logic               cfg_err;
    logic [SRV_W-1:0]   cfg_rd_server;
    logic [PRIO_W-1:0]  cfg_rd_prio;
    logic               offer_valid;
    logic               offer_ready = 1'b1;
    logic [SRV_W-1:0]   offer_server;
    logic [NUM_W-1:0]   offer_num;
    logic [PRIO_W-1:0]  offer_prio;
    logic               scan_busy;

    always #4 clk = ~clk;

    irqsrc_ctrl #(
        .NUM_SRC (NUM_SRC), .NUM_SERVERS (3), .SRV_W (SRV_W),
        .PRIO_W (PRIO_W), .NUM_W (NUM_W), .BASE (BASE)
    ) u_irqsrc_ctrl (
        .clk (clk), .rst_n (rst_n), .line_in (line_in), .src_is_level (src_is_level),
        .resend_req (resend_req), .reject_valid (reject_valid), .reject_num (reject_num),
        .eoi_valid (eoi_valid), .eoi_num (eoi_num), .cfg_valid (cfg_valid),
        .cfg_ready (cfg_ready), .cfg_op (cfg_op), .cfg_num (cfg_num),
        .cfg_server (cfg_server), .cfg_prio (cfg_prio), .cfg_done (cfg_done),
        .cfg_err (cfg_err), .cfg_rd_server (cfg_rd_server), .cfg_rd_prio (cfg_rd_prio),
        .offer_valid (offer_valid), .offer_ready (offer_ready),
        .offer_server (offer_server), .offer_num (offer_num),
        .offer_prio (offer_prio), .scan_busy (scan_busy)
    );

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // Monitor: records every offer taken by the presentation side
    int mon_total = 0;
    int cap_num [64];
    int cap_prio [64];
    int cap_srv [64];
    always @(posedge clk) begin
        if (rst_n && offer_valid && offer_ready) begin
            if (mon_total < 64) begin
                cap_num[mon_total]  <= int'(offer_num);
                cap_prio[mon_total] <= int'(offer_prio);
                cap_srv[mon_total]  <= int'(offer_server);
            end
            mon_total <= mon_total + 1;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    int r_err, r_srv, r_prio, r_done;
    task automatic cfg_cmd(input logic [1:0] op, input int num, input int srv, input int prio);
        while (!cfg_ready) @(negedge clk);
        cfg_valid  = 1'b1;
        cfg_op     = op;
        cfg_num    = NUM_W'(num);
        cfg_server = SRV_W'(srv);
        cfg_prio   = PRIO_W'(prio);
        @(negedge clk);
        cfg_valid = 1'b0;
        r_done = int'(cfg_done);
        r_err  = int'(cfg_err);
        r_srv  = int'(cfg_rd_server);
        r_prio = int'(cfg_rd_prio);
    endtask

    task automatic pulse_line(input int i);
        line_in[i] = 1'b1;
        @(negedge clk);
        line_in[i] = 1'b0;
    endtask

    task automatic do_reject(input int num);
        reject_valid = 1'b1;
        reject_num = NUM_W'(num);
        @(negedge clk);
        reject_valid = 1'b0;
    endtask

    task automatic do_eoi(input int num);
        eoi_valid = 1'b1;
        eoi_num = NUM_W'(num);
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic do_resend();
        resend_req = 1'b1;
        @(negedge clk);
        resend_req = 1'b0;
    endtask

    // Command table: op 0 set, 1 get, 2 disable, 3 enable
    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] num;
        logic [3:0]  srv;
        logic [7:0]  prio;
        logic        err;
        logic [3:0]  rsrv;
        logic [7:0]  rprio;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 12'd16, 4'd0, 8'h00, 1'b0, 4'd0, 8'hFF},  // R1 reset read
        '{2'd0, 12'd17, 4'd2, 8'h40, 1'b0, 4'd0, 8'h00},  // R7 set
        '{2'd1, 12'd17, 4'd0, 8'h00, 1'b0, 4'd2, 8'h40},  // R7 read back
        '{2'd2, 12'd17, 4'd0, 8'h00, 1'b0, 4'd0, 8'h00},  // R8 disable
        '{2'd1, 12'd17, 4'd0, 8'h00, 1'b0, 4'd2, 8'hFF},  // R8 masked
        '{2'd3, 12'd17, 4'd0, 8'h00, 1'b0, 4'd0, 8'h00},  // R8 enable
        '{2'd1, 12'd17, 4'd0, 8'h00, 1'b0, 4'd2, 8'h40},  // R8 restored
        '{2'd0, 12'd15, 4'd1, 8'h11, 1'b1, 4'd0, 8'h00},  // R9 below base
        '{2'd0, 12'd32, 4'd1, 8'h11, 1'b1, 4'd0, 8'h00},  // R9 past end
        '{2'd0, 12'd17, 4'd3, 8'h10, 1'b1, 4'd0, 8'h00},  // R9 bad server
        '{2'd1, 12'd17, 4'd0, 8'h00, 1'b0, 4'd2, 8'h40},  // R9 unchanged
        '{2'd1, 12'd31, 4'd0, 8'h00, 1'b0, 4'd0, 8'hFF}   // R1 last source
    };

    int base_cnt;

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state at the ports
        chk("R1 offer_valid after reset", int'(offer_valid), 0);
        chk("R1 scan_busy after reset", int'(scan_busy), 0);
        chk("R1 cfg_done after reset", int'(cfg_done), 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            cfg_cmd(VEC[v].op, int'(VEC[v].num), int'(VEC[v].srv), int'(VEC[v].prio));
            chk($sformatf("R7 vec%0d done", v), r_done, 1);
            chk($sformatf("R9 vec%0d err", v), r_err, int'(VEC[v].err));
            chk($sformatf("R7 vec%0d rd server", v), r_srv, int'(VEC[v].rsrv));
            chk($sformatf("R8 vec%0d rd prio", v), r_prio, int'(VEC[v].rprio));
        end
        idle(2);
        chk("R9 no offers from config table", mon_total, 0);

        // R2 unmasked message source 2
        cfg_cmd(2'd0, 18, 1, 8'h20);
        base_cnt = mon_total;
        pulse_line(2);
        idle(4);
        chk("R2 one offer", mon_total - base_cnt, 1);
        chk("R2 offer number", cap_num[base_cnt], 18);
        chk("R2 offer prio", cap_prio[base_cnt], 8'h20);
        chk("R2 offer server", cap_srv[base_cnt], 1);

        // R2 masked message source 3, then R7 release of masked-pending
        base_cnt = mon_total;
        pulse_line(3);
        idle(4);
        chk("R2 masked fire no offer", mon_total - base_cnt, 0);
        cfg_cmd(2'd0, 19, 0, 8'h30);
        idle(3);
        chk("R7 masked-pending released", mon_total - base_cnt, 1);
        chk("R7 released number", cap_num[base_cnt], 19);
        chk("R7 released prio", cap_prio[base_cnt], 8'h30);

        // R3 level source 4 held high offers once
        cfg_cmd(2'd0, 20, 2, 8'h08);
        base_cnt = mon_total;
        line_in[4] = 1'b1;
        idle(4);
        chk("R3 level offer", mon_total - base_cnt, 1);
        chk("R3 level number", cap_num[base_cnt], 20);
        idle(6);
        chk("R3 no repeat while sent", mon_total - base_cnt, 1);

        // R6 end-of-interrupt on level then a scan re-offers
        base_cnt = mon_total;
        do_eoi(20);
        idle(3);
        chk("R6 eoi alone no offer", mon_total - base_cnt, 0);
        do_resend();
        idle(20);
        chk("R6 level re-offer after eoi", mon_total - base_cnt, 1);
        chk("R6 re-offer number", cap_num[base_cnt], 20);

        // R6 end-of-interrupt on a message source has no effect
        base_cnt = mon_total;
        do_eoi(18);
        do_resend();
        idle(20);
        chk("R6 message eoi no effect", mon_total - base_cnt, 0);

        // R4 reject of a sent level source clears sent
        base_cnt = mon_total;
        do_reject(20);
        do_resend();
        idle(20);
        chk("R4 level re-offer after reject", mon_total - base_cnt, 1);

        // R11 and R5 scan order
        base_cnt = mon_total;
        do_reject(18);
        do_reject(17);
        do_resend();
        idle(20);
        chk("R5 two re-offers", mon_total - base_cnt, 2);
        chk("R11 first is lower index", cap_num[base_cnt], 17);
        chk("R11 second", cap_num[base_cnt + 1], 18);
        chk("R5 prio of 17", cap_prio[base_cnt], 8'h40);

        // R5 rejected but disabled: flag cleared without offer
        base_cnt = mon_total;
        do_reject(19);
        cfg_cmd(2'd2, 19, 0, 0);
        do_resend();
        idle(20);
        chk("R5 masked rejected no offer", mon_total - base_cnt, 0);
        cfg_cmd(2'd3, 19, 0, 0);
        do_resend();
        idle(20);
        chk("R5 rejected flag was cleared", mon_total - base_cnt, 0);

        // R11 line event waits for the running scan
        cfg_cmd(2'd0, 16, 0, 8'h60);
        cfg_cmd(2'd0, 25, 1, 8'h50);
        base_cnt = mon_total;
        do_reject(25);
        resend_req = 1'b1;
        line_in[0] = 1'b1;
        @(negedge clk);
        resend_req = 1'b0;
        line_in[0] = 1'b0;
        idle(25);
        chk("R11 two offers", mon_total - base_cnt, 2);
        chk("R11 scan offer first", cap_num[base_cnt], 25);
        chk("R11 line offer after scan", cap_num[base_cnt + 1], 16);

        // R10 backpressure
        base_cnt = mon_total;
        offer_ready = 1'b0;
        pulse_line(2);
        idle(5);
        chk("R10 offer held", int'(offer_valid), 1);
        chk("R10 held number", int'(offer_num), 18);
        chk("R10 cfg blocked", int'(cfg_ready), 0);
        chk("R10 nothing taken", mon_total - base_cnt, 0);
        offer_ready = 1'b1;
        idle(2);
        chk("R10 taken once", mon_total - base_cnt, 1);

        // R1 reset mid-run
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 offer cleared by reset", int'(offer_valid), 0);
        cfg_cmd(2'd1, 17, 0, 0);
        chk("R1 server after reset", r_srv, 0);
        chk("R1 prio after reset", r_prio, 8'hFF);
        base_cnt = mon_total;
        idle(4);
        chk("R1 masked level no offer", mon_total - base_cnt, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule